// File: doc/BRIEF.md
# Dual Timer/Counter with Four Operating Modes

This block holds two 8+8-bit count channels and a clock prescaler. The prescaler divides the core clock to make a machine-cycle tick. Each channel advances on that tick (timer use) or on falling edges of its own count pin (counter use). A gate option lets an external level enable counting. When a channel rolls over it sets an overflow flag and emits a one-cycle pulse.

Software reaches the block through a small register port: a mode byte, a control byte and four count bytes. Each channel has four modes:
- a 13-bit prescaled counter;
- a 16-bit free counter;
- an 8-bit counter that reloads from the high byte;
- a split mode. Here channel 0 becomes two independent 8-bit timers and channel 1 holds still.

A separate pulse marks overflows of channel 1's own counter. A serial baud generator can use it.

Top module: `tmr_pair`

## Requirements
- R1: After reset the mode byte, the control byte and all four count bytes read 0x00, and `ovf_o` and `baud_tick_o` are low.
- R2: An enabled timer-use channel advances by exactly one for every PRESCALE (default 12) core clock cycles. It never changes between ticks unless its count bytes are written.
- R3: Mode 01 is a 16-bit counter, with the high byte at address 3 or 5 and the low byte at address 2 or 4. Stepping from 0xFFFF gives 0x0000, sets the channel's flag and raises its `ovf_o` bit for exactly one cycle.
- R4: Mode 00 counts in low-byte bits 4:0 with a carry into the high byte. Low-byte bits 7:5 keep their value. A step from high 0xFF with low bits 0x1F wraps both to zero and sets the flag.
- R5: In mode 10 only the low byte counts. A step from 0xFF loads the low byte from the high byte and sets the flag. The high byte does not change.
- R6: When channel 0 is in mode 11:
  - its low byte is an 8-bit timer under run bit 0 and sets flag 0;
  - its high byte is an 8-bit timer on machine ticks under run bit 1 and sets flag 1;
  - channel 1's count bytes hold.
- R7: With the count-source bit set, a channel advances once for each 1-to-0 change seen between two consecutive machine-cycle samples of its count pin. Machine ticks alone do not advance it.
- R8: With the gate bit set, a channel counts only while both its run bit and its gate pin are high. With the gate bit clear, the gate pin has no effect.
- R9: The mode byte (address 0) holds channel 1 in bits 7:4 and channel 0 in bits 3:0. Each nibble is, high to low: gate, count source, mode[1:0].
- R10: The control byte (address 1) holds run0 in bit 0, run1 in bit 1, flag0 in bit 2 and flag1 in bit 3. A write loads all four. A written 0 clears a flag, but an overflow in the same cycle still sets it.
- R11: A count byte write wins over counting in the same cycle. It reads back on the next cycle, and counting continues from the written value.
- R12: `baud_tick_o` pulses for each overflow of channel 1's own counter. It does not pulse for the split-mode high-byte overflow that sets flag 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address: 0 mode, 1 control, 2/3 ch0 low/high, 4/5 ch1 low/high |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| cnt_pin_i | input | 2 | External count pins, one per channel |
| gate_pin_i | input | 2 | External gate pins, one per channel |
| ovf_o | output | 2 | One-cycle pulse per channel when its flag is set |
| baud_tick_o | output | 1 | One-cycle pulse on channel 1 counter overflow |

## Verification
The checker enforces several rules on every cycle:
- counts only move on a tick or a write;
- the high byte stays constant in reload mode;
- channel 1 is frozen while channel 0 is split;
- overflow pulses last one cycle and always carry their flag;
- the baud pulse only appears together with flag 1.

The bench scenarios are the only way to show the actual count arithmetic. That covers wrap values in each mode, the preserved low-byte upper bits in 13-bit mode, the reload value, falling-edge counting on a pin, gate behaviour, and write precedence over a concurrent count.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int BYTE_W  = 8;
  localparam int NUM_CH  = 2;
  localparam int LOW13_W = 5;
  localparam int ADDR_W  = 3;

  typedef enum logic [1:0] {
    MODE_13     = 2'b00,
    MODE_16     = 2'b01,
    MODE_RELOAD = 2'b10,
    MODE_SPLIT  = 2'b11
  } tmr_mode_e;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_LO0  = 3'd2;
  localparam logic [ADDR_W-1:0] A_HI0  = 3'd3;
  localparam logic [ADDR_W-1:0] A_LO1  = 3'd4;
  localparam logic [ADDR_W-1:0] A_HI1  = 3'd5;
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
  parameter int PRESCALE = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/tmr_pin_sync.sv
`timescale 1ns/1ps
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cnt_pin_i,
  input  logic gate_pin_i,
  output logic fall_o,
  output logic gate_o
);
  logic [STAGES-1:0] cnt_s, gate_s;
  logic              smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_s  <= '0;
      gate_s <= '0;
      smp_q  <= 1'b0;
    end else begin
      cnt_s  <= {cnt_s[STAGES-2:0], cnt_pin_i};
      gate_s <= {gate_s[STAGES-2:0], gate_pin_i};
      if (tick_i) smp_q <= cnt_s[STAGES-1];
    end
  end

  // one event per high sample followed by a low sample
  assign fall_o = tick_i & smp_q & ~cnt_s[STAGES-1];
  assign gate_o = gate_s[STAGES-1];
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import tmr_pkg::*;
#(
  parameter bit SPLIT_OK = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tmr_mode_e         mode_i,
  input  logic              inc_lo_i,
  input  logic              inc_hi_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              ovf_lo_o,
  output logic              ovf_hi_o
);
  localparam int W13 = BYTE_W + LOW13_W;

  logic [BYTE_W-1:0] lo_q, hi_q, lo_n, hi_n;
  logic [W13-1:0]    s13;
  logic [2*BYTE_W-1:0] s16;

  always_comb begin
    lo_n     = lo_q;
    hi_n     = hi_q;
    ovf_lo_o = 1'b0;
    ovf_hi_o = 1'b0;
    s13      = {hi_q, lo_q[LOW13_W-1:0]} + W13'(1);
    s16      = {hi_q, lo_q} + 16'd1;
    if (inc_lo_i) begin
      unique case (mode_i)
        MODE_13: begin
          hi_n               = s13[W13-1:LOW13_W];
          lo_n[LOW13_W-1:0]  = s13[LOW13_W-1:0];
          ovf_lo_o           = &{hi_q, lo_q[LOW13_W-1:0]};
        end
        MODE_16: begin
          {hi_n, lo_n} = s16;
          ovf_lo_o     = &{hi_q, lo_q};
        end
        MODE_RELOAD: begin
          lo_n     = (&lo_q) ? hi_q : lo_q + 1'b1;
          ovf_lo_o = &lo_q;
        end
        MODE_SPLIT: begin
          if (SPLIT_OK) begin
            lo_n     = lo_q + 1'b1;
            ovf_lo_o = &lo_q;
          end
        end
        default: ;
      endcase
    end
    if (SPLIT_OK && inc_hi_i && mode_i == MODE_SPLIT) begin
      hi_n     = hi_q + 1'b1;
      ovf_hi_o = &hi_q;
    end
    if (wr_lo_i) lo_n = wdata_i;
    if (wr_hi_i) hi_n = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/tmr_pair.sv
`timescale 1ns/1ps
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int PRESCALE = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] cnt_pin_i,
  input  logic [NUM_CH-1:0] gate_pin_i,
  output logic [NUM_CH-1:0] ovf_o,
  output logic              baud_tick_o
);
  logic                          tick;
  logic [BYTE_W-1:0]             mode_q;
  logic [NUM_CH-1:0]             run_q, flag_q, ovf_q;
  logic                          baud_q;
  logic [NUM_CH-1:0]             fall, gate_lvl, inc_lo, inc_hi, wr_lo, wr_hi;
  logic [NUM_CH-1:0]             ovf_lo, ovf_hi;
  logic [NUM_CH-1:0][BYTE_W-1:0] lo_c, hi_c;
  logic [NUM_CH-1:0]             set_ev;
  logic                          split0;

  tmr_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  assign split0 = (tmr_mode_e'(mode_q[1:0]) == MODE_SPLIT);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [3:0] nib;
    logic       en_ok;
    assign nib = mode_q[4*g +: 4];

    tmr_pin_sync u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
      .cnt_pin_i(cnt_pin_i[g]), .gate_pin_i(gate_pin_i[g]),
      .fall_o(fall[g]), .gate_o(gate_lvl[g])
    );

    assign en_ok     = run_q[g] & (~nib[3] | gate_lvl[g]) & (nib[2] ? fall[g] : tick);
    assign inc_lo[g] = (g == 1) ? (en_ok & ~split0) : en_ok;
    assign inc_hi[g] = (g == 0) ? (tick & run_q[1]) : 1'b0;
    assign wr_lo[g]  = wr_i && (addr_i == A_LO0 + ADDR_W'(2*g));
    assign wr_hi[g]  = wr_i && (addr_i == A_HI0 + ADDR_W'(2*g));

    tmr_channel #(.SPLIT_OK(g == 0)) u_ch (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .mode_i(tmr_mode_e'(nib[1:0])),
      .inc_lo_i(inc_lo[g]), .inc_hi_i(inc_hi[g]),
      .wr_lo_i(wr_lo[g]), .wr_hi_i(wr_hi[g]), .wdata_i(wdata_i),
      .lo_o(lo_c[g]), .hi_o(hi_c[g]),
      .ovf_lo_o(ovf_lo[g]), .ovf_hi_o(ovf_hi[g])
    );
  end

  assign set_ev = {ovf_lo[1] | ovf_hi[0], ovf_lo[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
      ovf_q  <= '0;
      baud_q <= 1'b0;
    end else begin
      ovf_q  <= set_ev;
      baud_q <= ovf_lo[1];
      if (wr_i && addr_i == A_MODE) mode_q <= wdata_i;
      if (wr_i && addr_i == A_CTRL) begin
        run_q  <= wdata_i[1:0];
        flag_q <= wdata_i[3:2] | set_ev;
      end else begin
        flag_q <= flag_q | set_ev;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      A_MODE:  rdata_o = mode_q;
      A_CTRL:  rdata_o = {4'b0, flag_q, run_q};
      A_LO0:   rdata_o = lo_c[0];
      A_HI0:   rdata_o = hi_c[0];
      A_LO1:   rdata_o = lo_c[1];
      A_HI1:   rdata_o = hi_c[1];
      default: rdata_o = '0;
    endcase
  end

  assign ovf_o       = ovf_q;
  assign baud_tick_o = baud_q;
endmodule

// File: rtl/tmr_pair_chk.sv
`timescale 1ns/1ps
module tmr_pair_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_i,
  input logic        tick_i,
  input logic [7:0]  mode_i,
  input logic [1:0]  flag_i,
  input logic [1:0]  ovf_i,
  input logic        baud_i,
  input logic [15:0] cnt0_i,
  input logic [15:0] cnt1_i
);
  a_r2_no_move_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_i) |=> $stable(cnt0_i) && $stable(cnt1_i));

  a_r3_ovf_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i[0] |=> !ovf_i[0]);

  a_r5_reload_high_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1:0] == 2'b10 && !wr_i) |=> $stable(cnt0_i[15:8]));

  a_r6_ch1_frozen_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1:0] == 2'b11 && !wr_i) |=> $stable(cnt1_i));

  a_r10_ovf0_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i[0] |-> flag_i[0]);

  a_r10_ovf1_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i[1] |-> flag_i[1]);

  a_r12_baud_with_ovf1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_i |-> ovf_i[1]);
endmodule

bind tmr_pair tmr_pair_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .tick_i(tick),
  .mode_i(mode_q), .flag_i(flag_q), .ovf_i(ovf_o), .baud_i(baud_tick_o),
  .cnt0_i({hi_c[0], lo_c[0]}), .cnt1_i({hi_c[1], lo_c[1]})
);

// File: tb/sim_tmr_pair.sv
`timescale 1ns/1ps
module sim_tmr_pair;
  localparam int PRE = 12;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [1:0] cnt_pin_i = '0;
  logic [1:0] gate_pin_i = '0;
  logic [1:0] ovf_o;
  logic       baud_tick_o;

  always #5 clk = ~clk;

  tmr_pair #(.PRESCALE(PRE)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cnt_pin_i(cnt_pin_i),
    .gate_pin_i(gate_pin_i), .ovf_o(ovf_o), .baud_tick_o(baud_tick_o)
  );

  typedef struct {
    int    sel;
    int    exp;
    string req;
  } item_t;

  item_t q[$];
  event  smp_ev;
  int    n_chk = 0, n_err = 0;
  int    n_ovf0 = 0, n_ovf1 = 0, n_baud = 0;
  bit    done = 1'b0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (ovf_o[0])    n_ovf0++;
      if (ovf_o[1])    n_ovf1++;
      if (baud_tick_o) n_baud++;
    end
  end

  // monitor: pops expected items and compares with observed values
  initial begin
    forever begin
      item_t it;
      int    act;
      @(smp_ev);
      it = q.pop_front();
      case (it.sel)
        8:       act = n_ovf0;
        9:       act = n_ovf1;
        10:      act = n_baud;
        default: act = int'(rdata_o);
      endcase
      n_chk++;
      if (act != it.exp) begin
        n_err++;
        $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic expect_v(input int sel, input int exp, input string req);
    item_t it;
    if (sel < 8) addr_i = 3'(sel);
    it.sel = sel; it.exp = exp; it.req = req;
    q.push_back(it);
    #0.2;
    -> smp_ev;
    #0.2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk);
    #1 wr_i = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    repeat (PRE * n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 6; a++) expect_v(a, 0, "R1 reset");
    expect_v(8, 0, "R1 ovf0");
    expect_v(10, 0, "R1 baud");

    // R3: 16-bit wrap
    wr(0, 8'h01); wr(2, 8'hFD); wr(3, 8'hFF); wr(1, 8'h01);
    wait_ticks(5);
    expect_v(2, 8'h02, "R3 lo");
    expect_v(3, 8'h00, "R3 hi");
    expect_v(1, 8'h05, "R3 flag");
    expect_v(8, 1, "R3 pulse");
    expect_v(0, 8'h01, "R9 mode readback");
    wr(1, 8'h00);
    @(negedge clk);
    expect_v(1, 8'h00, "R10 clear");

    // R4: 13-bit carry, then wrap with bits 7:5 kept
    wr(0, 8'h00); wr(2, 8'h3F); wr(3, 8'h12); wr(1, 8'h01);
    wait_ticks(1);
    expect_v(2, 8'h20, "R4 carry lo");
    expect_v(3, 8'h13, "R4 carry hi");
    wr(1, 8'h00);
    wr(2, 8'h5E); wr(3, 8'hFF); wr(1, 8'h01);
    wait_ticks(3);
    expect_v(2, 8'h41, "R4 wrap lo");
    expect_v(3, 8'h00, "R4 wrap hi");
    expect_v(1, 8'h05, "R4 flag");
    expect_v(8, 2, "R4 pulse");
    wr(1, 8'h01);
    @(negedge clk);
    expect_v(1, 8'h01, "R10 clear flag keep run");
    wr(1, 8'h00);

    // R5/R12: channel 1 reload
    wr(0, 8'h20); wr(4, 8'hFE); wr(5, 8'hA0); wr(1, 8'h02);
    wait_ticks(4);
    expect_v(4, 8'hA2, "R5 lo");
    expect_v(5, 8'hA0, "R5 hi");
    expect_v(1, 8'h0A, "R5 flag");
    expect_v(9, 1, "R5 pulse");
    expect_v(10, 1, "R12 baud");
    wr(1, 8'h00);

    // R6/R12: split mode
    wr(0, 8'h03); wr(2, 8'hFE); wr(3, 8'hFD); wr(4, 8'h33); wr(5, 8'h44);
    wr(1, 8'h03);
    wait_ticks(4);
    expect_v(2, 8'h02, "R6 lo0");
    expect_v(3, 8'h01, "R6 hi0");
    expect_v(4, 8'h33, "R6 lo1 frozen");
    expect_v(5, 8'h44, "R6 hi1 frozen");
    expect_v(1, 8'h0F, "R6 flags");
    expect_v(8, 3, "R6 ovf0");
    expect_v(9, 2, "R6 ovf1");
    expect_v(10, 1, "R12 no baud on split");
    wr(1, 8'h00);

    // R8: gate
    wr(0, 8'h09); wr(2, 8'h10); wr(3, 8'h00); wr(1, 8'h01);
    wait_ticks(5);
    expect_v(2, 8'h10, "R8 gate low blocks");
    wr(1, 8'h00);
    gate_pin_i[0] = 1'b1;
    repeat (5) @(posedge clk);
    wr(1, 8'h01);
    wait_ticks(5);
    expect_v(2, 8'h15, "R8 gate high counts");
    wr(1, 8'h00);
    gate_pin_i[0] = 1'b0;
    wr(0, 8'h01); wr(2, 8'h00); wr(1, 8'h01);
    wait_ticks(7);
    expect_v(2, 8'h07, "R8 R2 gate ignored, 7 ticks");
    wr(1, 8'h00);

    // R7: external falling edges
    wr(0, 8'h05); wr(2, 8'h00); wr(3, 8'h00);
    cnt_pin_i[0] = 1'b1;
    repeat (30) @(posedge clk);
    wr(1, 8'h01);
    for (int k = 0; k < 3; k++) begin
      repeat (36) @(posedge clk);
      cnt_pin_i[0] = 1'b0;
      repeat (36) @(posedge clk);
      cnt_pin_i[0] = 1'b1;
    end
    repeat (36) @(posedge clk);
    @(negedge clk);
    expect_v(2, 8'h03, "R7 edge count");
    expect_v(3, 8'h00, "R7 hi");
    wr(1, 8'h00);

    // R11: write while running
    wr(0, 8'h01); wr(2, 8'h10); wr(3, 8'h00); wr(1, 8'h01);
    wait_ticks(3);
    wr(2, 8'h80);
    @(negedge clk);
    expect_v(2, 8'h80, "R11 write visible");
    wait_ticks(2);
    expect_v(2, 8'h82, "R11 continues");
    wr(1, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule